// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block gathers 32 level-sensitive request lines and drives two interrupt outputs: a fast one and a normal one. Software reaches it through a small register bus. Each line has two settings:

- an enable bit;
- a class bit, which steers the line to the fast or the normal output.

Software can also raise any line itself through a soft-request bit. Enable bits and soft bits are changed only through write-one set and clear registers. Two status registers show the active requests of each class, and a raw register shows the merged request of every line.

Sixteen priority slots each bind one source index to a handler address. Reading the vector register returns a handler address:

- the address of the highest-priority slot whose source has an active normal request;
- otherwise, a programmable default address.

A read that returns a slot address also captures that slot in a two-state arbiter:

- `ARB_IDLE`: every slot may be chosen.
- `ARB_SERVICE`: the captured slot is held.

The arbiter has three named transitions:

- **capture** (`ARB_IDLE` to `ARB_SERVICE`): a vector read while a slot qualifies.
- **preempt** (`ARB_SERVICE` to `ARB_SERVICE` with a new level): a vector read while a higher-priority slot qualifies.
- **acknowledge** (`ARB_SERVICE` to `ARB_IDLE`): any write to the vector register.

While in `ARB_SERVICE`, only slots of higher priority than the captured one may replace the returned address.

Register offsets are byte addresses with bits 1:0 zero:

| Offset | Access | Content |
|---|---|---|
| 0x000 | read | fast status |
| 0x004 | read | normal status |
| 0x008 | read | raw requests |
| 0x00C | read/write | class select |
| 0x010 | read: enables; write: enable-set | enables |
| 0x014 | write | enable-clear |
| 0x018 | read: soft bits; write: soft-set | soft requests |
| 0x01C | write | soft-clear |
| 0x030 | read: vector; write: acknowledge | vector |
| 0x034 | read/write | default address |
| 0x100 + 4n | read/write | slot n address |
| 0x200 + 4n | read/write | slot n control |

Read data is registered: it appears on `rdata` the cycle after the `rd_en` edge.

Top module: `vic_ctrl`

## Requirements
- R1: A class-select bit of 1 makes a source fast and 0 makes it normal. Fast status (0x000) is raw AND enable AND select. Normal status (0x004) is raw AND enable AND NOT select. `fiq_o` is the OR of fast status and `irq_o` is the OR of normal status, several fast sources at once being allowed.
- R2: The raw request of a line (0x008) is the OR of its external input and its soft bit.
- R3: Writing 1s to enable-set (0x010) sets those enable bits, and writing 1s to enable-clear (0x014) clears them. Zero bits in either write leave enables unchanged, and a read of 0x010 returns the enables.
- R4: Writing 1s to soft-set (0x018) sets soft bits and writing 1s to soft-clear (0x01C) clears them. For example, soft 0x5 followed by a clear of 0x1 leaves 0x4, and a clear of 0 changes nothing.
- R5: A slot control word holds the source index in bits 4:0 and the slot enable in bit 5 (0x26 means source 6 enabled). A slot whose enable bit is 0 is never chosen.
- R6: Slot 0 has the highest priority. A vector read returns the address of the lowest-numbered enabled slot whose source has an active normal request.
- R7: When no slot qualifies in `ARB_IDLE`, a vector read returns the default address (0x034), including when no request is active.
- R8: A source classed fast never selects a slot, even when a slot is bound to it.
- R9: In `ARB_SERVICE`, a vector read returns the held slot address unless a slot of higher priority than the held one qualifies. Such a higher slot is returned and becomes the held level (preempt).
- R10: Any write to the vector register (0x030) returns the arbiter to `ARB_IDLE`, and arbitration then restarts over all slots.
- R11: After reset every register is 0, so both outputs are low and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_line | input | 32 | External request lines, level sensitive |
| fiq_o | output | 1 | Fast interrupt output |
| irq_o | output | 1 | Normal interrupt output |

## Verification
Register writes take effect at the clock edge that samples `wr_en`. Both interrupt outputs follow combinationally from the registers and lines, so the bench checks the pins at the falling edge after a write finishes. A read is captured at the edge that samples `rd_en`, and `rdata` is compared at the next falling edge. The scoreboard's monitor pops one expected word for each read that was sampled, so every comparison is tied to exactly one read. The capture, preempt and acknowledge transitions become visible only at the next vector read, and the bench issues that read after the transition edge.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic {
        ARB_IDLE,
        ARB_SERVICE
    } arb_state_e;

    localparam logic [11:0] OFF_FSTAT   = 12'h000;
    localparam logic [11:0] OFF_NSTAT   = 12'h004;
    localparam logic [11:0] OFF_RAW     = 12'h008;
    localparam logic [11:0] OFF_SEL     = 12'h00C;
    localparam logic [11:0] OFF_ENSET   = 12'h010;
    localparam logic [11:0] OFF_ENCLR   = 12'h014;
    localparam logic [11:0] OFF_SOFTSET = 12'h018;
    localparam logic [11:0] OFF_SOFTCLR = 12'h01C;
    localparam logic [11:0] OFF_VEC     = 12'h030;
    localparam logic [11:0] OFF_DEF     = 12'h034;

endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    parameter int AW    = 12,
    parameter int DW    = 32,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [NSRC-1:0]             line_i,
    input  logic [DW-1:0]               vec_i,
    output logic [DW-1:0]               rdata,
    output logic [NSRC-1:0]             fstat_o,
    output logic [NSRC-1:0]             nstat_o,
    output logic [DW-1:0]               def_o,
    output logic [NSLOT-1:0][DW-1:0]    slot_addr_o,
    output logic [NSLOT-1:0][IDXW:0]    slot_ctrl_o,
    output logic                        rd_vec_o,
    output logic                        ack_o
);

    logic [NSRC-1:0] sel_q, en_q, soft_q, raw;
    logic [DW-1:0]   def_q;
    logic [NSLOT-1:0][DW-1:0] saddr_q;
    logic [NSLOT-1:0][IDXW:0] sctrl_q;
    logic [DW-1:0]   rmux;

    logic is_saddr, is_sctrl;
    logic [$clog2(NSLOT)-1:0] sidx;

    always_comb begin
        sidx     = addr[$clog2(NSLOT)+1:2];
        is_saddr = (addr[AW-1:8] == (AW-8)'(1)) && (addr[1:0] == 2'b00) &&
                   (int'(addr[7:2]) < NSLOT);
        is_sctrl = (addr[AW-1:8] == (AW-8)'(2)) && (addr[1:0] == 2'b00) &&
                   (int'(addr[7:2]) < NSLOT);
    end

    assign raw     = line_i | soft_q;
    assign fstat_o = raw & en_q & sel_q;
    assign nstat_o = raw & en_q & ~sel_q;
    assign def_o   = def_q;
    assign slot_addr_o = saddr_q;
    assign slot_ctrl_o = sctrl_q;
    assign rd_vec_o = rd_en && (addr == AW'(OFF_VEC));
    assign ack_o    = wr_en && (addr == AW'(OFF_VEC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            en_q    <= '0;
            soft_q  <= '0;
            def_q   <= '0;
            saddr_q <= '0;
            sctrl_q <= '0;
        end else if (wr_en) begin
            if (addr == AW'(OFF_SEL))     sel_q  <= wdata[NSRC-1:0];
            if (addr == AW'(OFF_ENSET))   en_q   <= en_q | wdata[NSRC-1:0];
            if (addr == AW'(OFF_ENCLR))   en_q   <= en_q & ~wdata[NSRC-1:0];
            if (addr == AW'(OFF_SOFTSET)) soft_q <= soft_q | wdata[NSRC-1:0];
            if (addr == AW'(OFF_SOFTCLR)) soft_q <= soft_q & ~wdata[NSRC-1:0];
            if (addr == AW'(OFF_DEF))     def_q  <= wdata;
            if (is_saddr) saddr_q[sidx] <= wdata;
            if (is_sctrl) sctrl_q[sidx] <= wdata[IDXW:0];
        end
    end

    always_comb begin
        rmux = '0;
        unique case (1'b1)
            addr == AW'(OFF_FSTAT):   rmux = DW'(fstat_o);
            addr == AW'(OFF_NSTAT):   rmux = DW'(nstat_o);
            addr == AW'(OFF_RAW):     rmux = DW'(raw);
            addr == AW'(OFF_SEL):     rmux = DW'(sel_q);
            addr == AW'(OFF_ENSET):   rmux = DW'(en_q);
            addr == AW'(OFF_SOFTSET): rmux = DW'(soft_q);
            addr == AW'(OFF_VEC):     rmux = vec_i;
            addr == AW'(OFF_DEF):     rmux = def_q;
            is_saddr:                 rmux = saddr_q[sidx];
            is_sctrl:                 rmux = DW'(sctrl_q[sidx]);
            default:                  rmux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rmux;
    end

    p_enset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFF_ENSET)) |=>
        ((en_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

    p_enclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFF_ENCLR)) |=>
        ((en_q & $past(wdata[NSRC-1:0])) == '0));

    p_enkeep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == AW'(OFF_ENSET) || addr == AW'(OFF_ENCLR))) |=>
        $stable(en_q));

    p_softclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFF_SOFTCLR)) |=>
        ((soft_q & $past(wdata[NSRC-1:0])) == '0) &&
        ((soft_q | $past(wdata[NSRC-1:0])) == ($past(soft_q) | $past(wdata[NSRC-1:0]))));

    p_class_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fstat_o & nstat_o) == '0);

endmodule

// File: rtl/vic_arb.sv
module vic_arb
    import vic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    parameter int DW    = 32,
    localparam int IDXW = $clog2(NSRC),
    localparam int SLW  = $clog2(NSLOT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             nstat_i,
    input  logic [NSLOT-1:0][DW-1:0]    slot_addr_i,
    input  logic [NSLOT-1:0][IDXW:0]    slot_ctrl_i,
    input  logic [DW-1:0]               def_i,
    input  logic                        rd_vec_i,
    input  logic                        ack_i,
    output logic [DW-1:0]               vec_o
);

    arb_state_e state_q, state_d;
    logic [SLW-1:0] lvl_q, lvl_d;
    logic [DW-1:0]  held_q, held_d;
    logic [NSLOT-1:0] hit, cand;
    logic [SLW-1:0] win;
    logic any;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign hit[s]  = slot_ctrl_i[s][IDXW] && nstat_i[slot_ctrl_i[s][IDXW-1:0]];
        assign cand[s] = hit[s] && ((state_q == ARB_IDLE) || (SLW'(s) < lvl_q));
    end

    always_comb begin
        any = 1'b0;
        win = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (cand[s]) begin
                any = 1'b1;
                win = SLW'(s);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        held_d  = held_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (!ack_i && rd_vec_i && any) begin
                    state_d = ARB_SERVICE;
                    lvl_d   = win;
                    held_d  = slot_addr_i[win];
                end
            end
            ARB_SERVICE: begin
                if (ack_i) begin
                    state_d = ARB_IDLE;
                end else if (rd_vec_i && any) begin
                    lvl_d  = win;
                    held_d = slot_addr_i[win];
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            lvl_q   <= '0;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ARB_IDLE:    vec_o = any ? slot_addr_i[win] : def_i;
            ARB_SERVICE: vec_o = any ? slot_addr_i[win] : held_q;
            default:     vec_o = def_i;
        endcase
    end

    p_win_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (cand[win] && ((cand & ((NSLOT'(1) << win) - NSLOT'(1))) == '0)));

    p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (state_q == ARB_IDLE));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_SERVICE && !ack_i && !rd_vec_i) |=>
        (state_q == ARB_SERVICE) && $stable(lvl_q) && $stable(held_q));

    p_preempt_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_SERVICE && !ack_i && rd_vec_i && any) |=>
        (lvl_q < $past(lvl_q)));

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    parameter int AW    = 12,
    parameter int DW    = 32,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            wr_en,
    input  logic            rd_en,
    output logic [DW-1:0]   rdata,
    input  logic [NSRC-1:0] irq_line,
    output logic            fiq_o,
    output logic            irq_o
);

    logic [NSRC-1:0] fstat, nstat;
    logic [DW-1:0]   def_addr, vec;
    logic [NSLOT-1:0][DW-1:0] slot_addr;
    logic [NSLOT-1:0][IDXW:0] slot_ctrl;
    logic rd_vec, ack;

    vic_regs #(.NSRC(NSRC), .NSLOT(NSLOT), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .line_i(irq_line), .vec_i(vec),
        .rdata(rdata), .fstat_o(fstat), .nstat_o(nstat), .def_o(def_addr),
        .slot_addr_o(slot_addr), .slot_ctrl_o(slot_ctrl),
        .rd_vec_o(rd_vec), .ack_o(ack)
    );

    vic_arb #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_arb (
        .clk(clk), .rst_n(rst_n), .nstat_i(nstat), .slot_addr_i(slot_addr),
        .slot_ctrl_i(slot_ctrl), .def_i(def_addr), .rd_vec_i(rd_vec),
        .ack_i(ack), .vec_o(vec)
    );

    assign fiq_o = |fstat;
    assign irq_o = |nstat;

    p_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_o || irq_o) |-> ((fstat | nstat) != '0));

endmodule

// File: tb/test_vic_ctrl.sv
module test_vic_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [31:0] irq_line = '0;
    logic        fiq_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic rd_was = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vic_ctrl i_vic_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .irq_line(irq_line), .fiq_o(fiq_o), .irq_o(irq_o)
    );

    always @(posedge clk) rd_was <= rd_en;

    always @(negedge clk) begin
        if (rd_was && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pins(input logic ef, input logic en, input string t);
        @(negedge clk);
        n_tests++;
        if (fiq_o !== ef || irq_o !== en) begin
            n_fail++;
            $display("FAIL %s: fiq=%b irq=%b expected fiq=%b irq=%b", t, fiq_o, irq_o, ef, en);
        end
    endtask

    task automatic lines(input logic [31:0] v);
        @(negedge clk);
        irq_line = v;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        pins(1'b0, 1'b0, "R11 pins");
        rd(12'h010, 32'h0, "R11 enables");
        rd(12'h030, 32'h0, "R11 vector");
        // R4 soft set/clear, R2 raw
        wr(12'h018, 32'h5);
        rd(12'h018, 32'h5, "R4 soft set");
        rd(12'h008, 32'h5, "R2 raw from soft");
        wr(12'h01C, 32'h1);
        rd(12'h018, 32'h4, "R4 soft clear 1");
        wr(12'h01C, 32'h0);
        rd(12'h018, 32'h4, "R4 soft clear 0");
        wr(12'h01C, 32'h4);
        // R2 external lines
        lines(32'h0000_04C0);
        rd(12'h008, 32'h0000_04C0, "R2 raw from lines");
        pins(1'b0, 1'b0, "R3 nothing enabled");
        // R3 enable set/clear
        wr(12'h010, 32'h0000_06C0);
        rd(12'h010, 32'h0000_06C0, "R3 enable set");
        rd(12'h004, 32'h0000_04C0, "R1 normal status");
        pins(1'b0, 1'b1, "R1 normal pin");
        wr(12'h014, 32'h0000_0080);
        rd(12'h010, 32'h0000_0640, "R3 enable clear");
        wr(12'h014, 32'h0);
        rd(12'h010, 32'h0000_0640, "R3 enable clear 0");
        // R1 fast class
        wr(12'h00C, 32'h0000_0200);
        lines(32'h0000_06C0);
        rd(12'h000, 32'h0000_0200, "R1 fast status");
        rd(12'h004, 32'h0000_0440, "R1 normal status split");
        pins(1'b1, 1'b1, "R1 both pins");
        // slots
        wr(12'h034, 32'h0000_D000);
        wr(12'h100, 32'h0000_A000);
        wr(12'h200, 32'h06);
        wr(12'h104, 32'h0000_B000);
        rd(12'h030, 32'h0000_D000, "R5 disabled slot ignored");
        wr(12'h200, 32'h26);
        wr(12'h204, 32'h2A);
        rd(12'h204, 32'h2A, "R5 slot control readback");
        rd(12'h030, 32'h0000_A000, "R6 slot 0 wins");
        wr(12'h030, 32'h0);
        // R8 fast source bound to a slot
        wr(12'h108, 32'h0000_C000);
        wr(12'h208, 32'h29);
        lines(32'h0000_0200);
        rd(12'h030, 32'h0000_D000, "R8 fast source not vectored");
        lines(32'h0);
        rd(12'h030, 32'h0000_D000, "R7 default with none active");
        // R9 preempt by higher slot
        lines(32'h0000_0400);
        rd(12'h030, 32'h0000_B000, "R6 slot 1 alone");
        lines(32'h0000_0440);
        rd(12'h030, 32'h0000_A000, "R9 higher slot preempts");
        wr(12'h030, 32'h0);
        // R9 lower slot does not replace
        wr(12'h10C, 32'h0000_E000);
        wr(12'h20C, 32'h2B);
        wr(12'h010, 32'h0000_0800);
        lines(32'h0000_0800);
        rd(12'h030, 32'h0000_E000, "R6 slot 3 alone");
        lines(32'h0000_0C00);
        rd(12'h030, 32'h0000_B000, "R9 slot 1 over held 3");
        lines(32'h0000_0800);
        rd(12'h030, 32'h0000_B000, "R9 lower slot held off");
        wr(12'h030, 32'h0);
        rd(12'h030, 32'h0000_E000, "R10 arbitration restarts");
        wr(12'h030, 32'h0);
        lines(32'h0);
        rd(12'h030, 32'h0000_D000, "R10 idle default");
        pins(1'b0, 1'b0, "R1 pins low");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL scoreboard: %0d left, expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule